// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block schedules the periodic auto-refresh (CAS-before-RAS) commands of an SDRAM controller. A free-running interval counter measures the time since the last refresh. When it reaches the programmed period, the sequencer first waits for any memory access in progress to finish. It then closes every internal bank that the controller reports as open, one after another. It waits out the row-precharge time, issues the refresh command and holds off new row activations until the refresh recovery time has passed.

The controller's command arbiter uses the two strobes and the bank index to place precharge and refresh commands on the SDRAM command bus. It gates its own activates with the inhibit output. The period, precharge-to-activate and recovery counts are live inputs, normally static fields that configuration logic sets. An access-busy flag and an open-bank bitmap come from the access engine.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `precharge_stb`, `refresh_stb`, `act_inhibit` and `bank_idx` are all 0, and the interval count is cleared.
- R2: The interval count is 0 in the first cycle after reset and in the cycle after each refresh strobe, and it rises by one per cycle. The sequence leaves idle at the end of the cycle in which the count equals `refresh_period` (14 bits), spends one arbitration cycle, and starts in the following cycle. Without stalls, the first refresh lands in cycle P+2+2N+T′ after reset release, and later refreshes are spaced P+3+2N+T′ cycles apart. Here P is the period, N the number of open banks, and T′ the clamped precharge-to-activate count.
- R3: While `access_busy` is high during arbitration, no precharge or refresh is issued and `act_inhibit` stays low. The sequence starts in the cycle after `access_busy` is sampled low.
- R4: Each bank whose bit is set in `open_banks` (sampled when arbitration ends) receives exactly one one-cycle `precharge_stb`, in ascending bank index order, with strobes two cycles apart. `bank_idx` carries the bank number during the strobe and is 0 at all other times.
- R5: Banks whose bit in `open_banks` is 0 get no precharge. With an all-zero bitmap, the sequence goes straight to the precharge-to-activate wait.
- R6: `refresh_stb` is asserted T′+2 cycles after the last precharge strobe, or T′ cycles after the sequence starts when no bank is open.
- R7: `refresh_stb` is a single-cycle pulse and is never asserted in the same cycle as `precharge_stb`.
- R8: `act_inhibit` is high from the first cycle of the sequence (first precharge, or the wait when no bank is open) through R′ cycles after the refresh cycle. R′ is the clamped `recovery` count. It is low at all other times.
- R9: A `pre_to_act` or `recovery` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_period | input | 14 | Refresh interval in cycles |
| pre_to_act | input | 4 | Precharge-to-refresh wait in cycles |
| recovery | input | 4 | Post-refresh activate lockout in cycles |
| access_busy | input | 1 | A memory access is in progress |
| open_banks | input | 4 | Bitmap of internal banks with an open row |
| precharge_stb | output | 1 | Issue a precharge to bank `bank_idx` |
| refresh_stb | output | 1 | Issue an auto-refresh command |
| bank_idx | output | 2 | Bank to precharge, valid with `precharge_stb` |
| act_inhibit | output | 1 | Block new bank activations |

## Verification
Every result depends only on the count of clock edges since reset release or since the previous refresh. The bench keeps its own cycle counter from reset release. From the period, the open bitmap, the clamped wait fields and the cycle in which busy is dropped, it computes the exact cycle of every precharge (with its bank) and of every refresh. Those cycle numbers go into queues, and a monitor samples the outputs on the falling edge and pops an entry whenever a strobe appears. A strobe that appears early, late or unexpectedly, or an entry left in a queue at the end of a test, is reported. The inhibit window is compared cycle by cycle against the bounds derived from the same arithmetic.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_ARB,
      S_PRE_CMD,
      S_PRE_GAP,
      S_TRP,
      S_REF,
      S_REC
   } ref_state_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] period,
   output logic             due
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         elapsed <= '0;
      else if (clear)
         elapsed <= '0;
      else if (elapsed != CNT_MAX)
         elapsed <= elapsed + 1'b1;
   end

   assign due = (elapsed >= period);

   // R2: a clear always restarts the count from zero
   a_r2_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (elapsed == '0));
endmodule

// File: rtl/ref_delay_cnt.sv
module ref_delay_cnt #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] value,
   output logic             done
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= value;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   // zero and one both end after a single cycle (R9)
   assign done = (cnt <= ONE);
endmodule

// File: rtl/ref_bank_pick.sv
module ref_bank_pick #(
   parameter int NBANK = 4,
   parameter int BI_W  = 2
) (
   input  logic [NBANK-1:0] pend,
   output logic [BI_W-1:0]  idx,
   output logic [NBANK-1:0] first
);
   // isolate the lowest pending bank
   assign first = pend & (~pend + 1'b1);

   always_comb begin
      idx = '0;
      for (int i = NBANK - 1; i >= 0; i--)
         if (pend[i]) idx = BI_W'(i);
   end

   a_r4_one_pick: assert final ($onehot0(first));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sdram_refresh_pkg::*;
#(
   parameter int INTV_W = 14,
   parameter int TIM_W  = 4,
   parameter int NBANK  = 4,
   localparam int BI_W  = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INTV_W-1:0] refresh_period,
   input  logic [TIM_W-1:0]  pre_to_act,
   input  logic [TIM_W-1:0]  recovery,
   input  logic              access_busy,
   input  logic [NBANK-1:0]  open_banks,
   output logic              precharge_stb,
   output logic              refresh_stb,
   output logic [BI_W-1:0]   bank_idx,
   output logic              act_inhibit
);
   generate
      if (INTV_W < 2) begin : g_bad_intv
         $error("INTV_W must be at least 2");
      end
      if (TIM_W < 1) begin : g_bad_tim
         $error("TIM_W must be at least 1");
      end
      if (NBANK < 2) begin : g_bad_nbank
         $error("NBANK must be at least 2");
      end
   endgenerate

   ref_state_t       st, st_nx;
   logic [NBANK-1:0] remain;
   logic [NBANK-1:0] first_bank;
   logic [BI_W-1:0]  pick_idx;
   logic             due, dly_done, dly_load;
   logic [TIM_W-1:0] dly_value;
   logic             arb_go, to_trp;

   ref_interval_timer #(.CNT_W(INTV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (st == S_REF),
      .period (refresh_period),
      .due    (due)
   );

   ref_bank_pick #(.NBANK(NBANK), .BI_W(BI_W)) u_pick (
      .pend  (remain),
      .idx   (pick_idx),
      .first (first_bank)
   );

   ref_delay_cnt #(.DLY_W(TIM_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dly_load),
      .value (dly_value),
      .done  (dly_done)
   );

   assign arb_go    = (st == S_ARB) && !access_busy;
   assign to_trp    = (arb_go && (open_banks == '0)) ||
                      ((st == S_PRE_GAP) && (remain == '0));
   assign dly_load  = to_trp || (st == S_REF);
   assign dly_value = (st == S_REF) ? recovery : pre_to_act;

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:    if (due) st_nx = S_ARB;
         S_ARB:     if (!access_busy)
                       st_nx = (open_banks != '0) ? S_PRE_CMD : S_TRP;
         S_PRE_CMD: st_nx = S_PRE_GAP;
         S_PRE_GAP: st_nx = (remain != '0) ? S_PRE_CMD : S_TRP;
         S_TRP:     if (dly_done) st_nx = S_REF;
         S_REF:     st_nx = S_REC;
         S_REC:     if (dly_done) st_nx = S_IDLE;
         default:   st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         remain <= '0;
      end else begin
         st <= st_nx;
         if (arb_go)
            remain <= open_banks;
         else if (st == S_PRE_CMD)
            remain <= remain & ~first_bank;
      end
   end

   assign precharge_stb = (st == S_PRE_CMD);
   assign refresh_stb   = (st == S_REF);
   assign bank_idx      = (st == S_PRE_CMD) ? pick_idx : '0;
   assign act_inhibit   = (st != S_IDLE) && (st != S_ARB);

   // R7: strobes are exclusive and the refresh lasts one cycle
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(precharge_stb && refresh_stb));
   a_r7_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_stb |=> !refresh_stb);
   // R4: precharge strobes are separated by a gap cycle
   a_r4_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_stb |=> !precharge_stb);
   // R8: activates are blocked around precharge and after refresh
   a_r8_inh_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_stb |-> act_inhibit);
   a_r8_inh_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_stb |=> act_inhibit);
   // R3: a busy access holds the sequence in arbitration
   a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ARB && access_busy) |=> (st == S_ARB && !precharge_stb));
   // R6: the refresh always follows the precharge-to-activate wait
   a_r6_ref_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_stb |-> $past(st) == S_TRP);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] refresh_period = 14'd20;
   logic [3:0]  pre_to_act = 4'd2;
   logic [3:0]  recovery = 4'd2;
   logic        access_busy = 1'b0;
   logic [3:0]  open_banks = 4'd0;
   logic        precharge_stb, refresh_stb, act_inhibit;
   logic [1:0]  bank_idx;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit running = 0;
   bit done = 0;
   int ilo = 0;
   int ihi = 0;
   string tag = "R1";
   int ref_q[$];
   int pre_q[$];

   always #2.5 clk = ~clk;

   sdram_refresh_sched u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .refresh_period (refresh_period),
      .pre_to_act     (pre_to_act),
      .recovery       (recovery),
      .access_busy    (access_busy),
      .open_banks     (open_banks),
      .precharge_stb  (precharge_stb),
      .refresh_stb    (refresh_stb),
      .bank_idx       (bank_idx),
      .act_inhibit    (act_inhibit)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
      end
   endtask

   // monitor: pop expected strobes as they appear
   always @(negedge clk) begin
      if (rst_n && running) begin
         if (refresh_stb) begin
            if (ref_q.size() == 0) check({tag, " R2"}, "unexpected refresh at cycle", cyc, -1);
            else check({tag, " R2 R6"}, "refresh cycle", cyc, ref_q.pop_front());
         end
         if (precharge_stb) begin
            if (pre_q.size() == 0) check({tag, " R5"}, "unexpected precharge cycle*16+bank", cyc * 16 + int'(bank_idx), -1);
            else check({tag, " R4"}, "precharge cycle*16+bank", cyc * 16 + int'(bank_idx), pre_q.pop_front());
         end else if (bank_idx != 2'd0) begin
            check({tag, " R4"}, "bank_idx idle", int'(bank_idx), 0);
         end
         if (precharge_stb && refresh_stb) check({tag, " R7"}, "overlap", 1, 0);
         if (cyc <= ihi + 1)
            check({tag, " R8"}, "act_inhibit", int'(act_inhibit), int'(cyc >= ilo && cyc <= ihi));
      end
   end

   // driver: compute the expected schedule, then run the stimulus
   task automatic run(input string t, input int p, input int trp, input int rec,
                      input logic [3:0] mask, input int busy_until, input int ncyc);
      int tp, rp, nb, start, sp;
      running = 0;
      rst_n = 0;
      tag = t;
      refresh_period = 14'(p);
      pre_to_act = 4'(trp);
      recovery = 4'(rec);
      open_banks = mask;
      access_busy = (busy_until > 0);
      tp = (trp == 0) ? 1 : trp;   // R9
      rp = (rec == 0) ? 1 : rec;   // R9
      nb = $countones(mask);
      sp = p + 3 + 2 * nb + tp;
      start = (busy_until + 1 > p + 2) ? busy_until + 1 : p + 2;
      ilo = start;
      ihi = start + 2 * nb + tp + rp;
      while (start < ncyc) begin
         int k;
         k = 0;
         for (int b = 0; b < 4; b++) begin
            if (mask[b]) begin
               if (start + 2 * k < ncyc) pre_q.push_back((start + 2 * k) * 16 + b);
               k++;
            end
         end
         if (start + 2 * nb + tp < ncyc) ref_q.push_back(start + 2 * nb + tp);
         start = start + sp;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      check("R1", "precharge_stb in reset", int'(precharge_stb), 0);
      check("R1", "refresh_stb in reset", int'(refresh_stb), 0);
      check("R1", "act_inhibit in reset", int'(act_inhibit), 0);
      check("R1", "bank_idx in reset", int'(bank_idx), 0);
      @(posedge clk); #1;
      rst_n = 1;
      running = 1;
      while (cyc < ncyc) begin
         @(posedge clk); #1;
         if (busy_until > 0 && cyc == busy_until) access_busy = 0;
      end
      running = 0;
      check({t, " R2"}, "refreshes left unseen", ref_q.size(), 0);
      check({t, " R4 R5"}, "precharges left unseen", pre_q.size(), 0);
      ref_q.delete();
      pre_q.delete();
   endtask

   initial begin
      // R2 R5 R6: no open bank, period 20
      run("T1 R5", 20, 2, 3, 4'b0000, 0, 80);
      // R4 R6: two open banks, ascending order
      run("T2 R4", 20, 3, 2, 4'b1010, 0, 62);
      // R3: access busy long past expiry
      run("T3 R3", 10, 1, 2, 4'b0001, 40, 62);
      // R9: zero wait fields act as one; R8 window
      run("T4 R9", 12, 0, 0, 4'b0100, 0, 40);
      // R4: all banks open
      run("T5 R4", 8, 2, 4, 4'b1111, 0, 60);
      // R2: longer period
      run("T6 R2", 300, 2, 1, 4'b0000, 0, 310);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule